// File: doc/BRIEF.md
# Pulse-Count Test Mode Selector with Observation Output

This block picks one test mode out of several by counting rising edges on a functional input pin that is borrowed as a pulse input while a static test-enable level is held. An entry detector elsewhere supplies that level. The pin is synchronised to the system clock. Each low-to-high change seen while the level is present advances a saturating counter. The counter value is decoded into a one-hot mode vector.

The selected mode routes the digital result of the matching internal block to one shared observation pin. With no mode selected, that pin carries its normal-operation value. Dropping the test-enable level returns the device to normal operation at once and clears the count, so the next entry starts from zero. The mode and enable pins are plain control signals with no handshake. The test-enable input is expected to be synchronous to `clk`.

Top module: `tm_pulse_decoder`

## Requirements
- R1: After reset, `mode_oh_o` is all zero and `obs_pin_o` equals `norm_out_i`.
- R2: While `test_en_i` is high, each low-to-high change of `en_pin_i` raises the mode number by one. The new value appears on `mode_oh_o` within SYNC_STAGES+2 clock cycles of the pin change. Mode k (1 to NUM_MODES) is shown by bit k-1 alone.
- R3: Exactly two pulses after entry select mode 2, which is bit 1 of `mode_oh_o`.
- R4: The mode number saturates at NUM_MODES. Pulses beyond that leave the highest mode selected.
- R5: When `test_en_i` is low, `mode_oh_o` is zero in the same cycle. The count is cleared, so a later entry starts again from no mode.
- R6: Pulses on `en_pin_i` while `test_en_i` is low have no effect on the mode after a later entry.
- R7: If `en_pin_i` is already high when `test_en_i` rises, that level is not counted. Only a later low-to-high change counts.
- R8: `mode_oh_o` is always one-hot or all zero.
- R9: With mode k selected, `obs_pin_o` equals bit k-1 of `blk_obs_i`.
- R10: With no mode selected, because `test_en_i` is low or no pulse has arrived yet, `obs_pin_o` equals `norm_out_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Static test-entry level from the entry detector |
| en_pin_i | input | 1 | Enable pin, used as the pulse input in test mode (asynchronous) |
| blk_obs_i | input | NUM_MODES | Digital outputs of the internal blocks; bit k-1 belongs to mode k |
| norm_out_i | input | 1 | Normal-operation value of the shared output pin |
| mode_oh_o | output | NUM_MODES | One-hot selected test mode, zero when none |
| obs_pin_o | output | 1 | Shared observation pin |

## Verification
A counter that skips or double-counts an edge leaves the wrong bit set in `mode_oh_o` a few cycles after the pulse. The shared pin then shows a block output other than the one the bench expects. A missing clear on exit only shows after the next entry, where the first pulse would land on a mode above 1. Stale edge history at entry shows as an extra count right after `test_en_i` rises. Every such fault therefore appears at the ports within SYNC_STAGES+2 cycles of the stimulus that exposes it.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int unsigned DEF_NUM_MODES   = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned modes);
    return $clog2(modes + 1);
  endfunction
endpackage

// File: rtl/tm_edge_sync.sv
module tm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // a rise is never reported in two consecutive cycles (R2)
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tm_pulse_counter.sv
module tm_pulse_counter #(
  parameter int unsigned NUM_MODES = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(NUM_MODES);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     cnt_q <= '0;
    else if (!enable_i)             cnt_q <= '0;
    else if (rise_i && cnt_q < TOP) cnt_q <= cnt_q + ONE;

  assign count_o = cnt_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && rise_i && cnt_q < TOP) |=> cnt_q == $past(cnt_q) + ONE);

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && cnt_q == TOP) |=> cnt_q == TOP);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> cnt_q == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tm_mode_decode.sv
module tm_mode_decode #(
  parameter int unsigned NUM_MODES = 8,
  parameter int unsigned CNT_W     = 4
) (
  input  logic                 enable_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic [NUM_MODES-1:0] mode_oh_o
);
  generate
    for (genvar k = 0; k < NUM_MODES; k++) begin : g_dec
      assign mode_oh_o[k] = enable_i && (count_i == CNT_W'(k + 1));
    end
  endgenerate

  always_comb
    assert_onehot_R8: assert ($onehot0(mode_oh_o));
endmodule

// File: rtl/tm_obs_mux.sv
module tm_obs_mux #(
  parameter int unsigned NUM_MODES = 8
) (
  input  logic [NUM_MODES-1:0] mode_oh_i,
  input  logic [NUM_MODES-1:0] blk_i,
  input  logic                 norm_i,
  output logic                 obs_o
);
  logic routed;

  assign routed = |(mode_oh_i & blk_i);
  assign obs_o  = (mode_oh_i == '0) ? norm_i : routed;
endmodule

// File: rtl/tm_pulse_decoder.sv
module tm_pulse_decoder #(
  parameter int unsigned NUM_MODES   = tm_pkg::DEF_NUM_MODES,
  parameter int unsigned SYNC_STAGES = tm_pkg::DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 test_en_i,
  input  logic                 en_pin_i,
  input  logic [NUM_MODES-1:0] blk_obs_i,
  input  logic                 norm_out_i,
  output logic [NUM_MODES-1:0] mode_oh_o,
  output logic                 obs_pin_o
);
  localparam int unsigned CNT_W = tm_pkg::cnt_width(NUM_MODES);

  logic             pin_rise;
  logic [CNT_W-1:0] mode_num;

  tm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(en_pin_i), .rise_o(pin_rise));

  tm_pulse_counter #(.NUM_MODES(NUM_MODES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable_i(test_en_i), .rise_i(pin_rise),
    .count_o(mode_num));

  tm_mode_decode #(.NUM_MODES(NUM_MODES), .CNT_W(CNT_W)) u_dec (
    .enable_i(test_en_i), .count_i(mode_num), .mode_oh_o(mode_oh_o));

  tm_obs_mux #(.NUM_MODES(NUM_MODES)) u_mux (
    .mode_oh_i(mode_oh_o), .blk_i(blk_obs_i), .norm_i(norm_out_i),
    .obs_o(obs_pin_o));

  assert_normal_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en_i |-> obs_pin_o == norm_out_i);

  assert_exit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en_i ##1 test_en_i) |-> mode_oh_o == '0);
endmodule

// File: tb/tm_pulse_decoder_test.sv
module tm_pulse_decoder_test;
  localparam int unsigned NM = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_en = 1'b0;
  logic          en_pin = 1'b0;
  logic [NM-1:0] blk = 8'b1010_0110;
  logic          norm = 1'b1;
  logic [NM-1:0] mode_oh;
  logic          obs;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tm_pulse_decoder #(.NUM_MODES(NM), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .test_en_i(test_en), .en_pin_i(en_pin),
    .blk_obs_i(blk), .norm_out_i(norm), .mode_oh_o(mode_oh), .obs_pin_o(obs));

  function automatic logic [NM-1:0] exp_oh(input int m);
    return (m == 0) ? '0 : (NM'(1) << (m - 1));
  endfunction

  task automatic check(input string req, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      en_pin = 1'b1; wait_neg(4);
      en_pin = 1'b0; wait_neg(4);
    end
  endtask

  task automatic leave_test;
    test_en = 1'b0; wait_neg(2);
  endtask

  task automatic t_reset;
    wait_neg(1);
    check("R1 mode", mode_oh, '0);
    check("R1 obs", NM'(obs), NM'(norm));
  endtask

  task automatic t_single_and_double;
    test_en = 1'b1; wait_neg(2);
    check("R10 no mode obs", NM'(obs), NM'(norm));
    en_pin = 1'b1; wait_neg(4);
    check("R2 one pulse", mode_oh, exp_oh(1));
    check("R9 mode1 obs", NM'(obs), NM'(blk[0]));
    en_pin = 1'b0; wait_neg(4);
    pulse(1);
    check("R3 two pulses", mode_oh, 8'b0000_0010);
    check("R9 mode2 obs", NM'(obs), NM'(blk[1]));
    leave_test();
    check("R5 mode zero on exit", mode_oh, '0);
    check("R10 obs on exit", NM'(obs), NM'(norm));
  endtask

  task automatic t_every_mode;
    test_en = 1'b1; wait_neg(2);
    for (int m = 1; m <= NM; m++) begin
      pulse(1);
      check("R2 step", mode_oh, exp_oh(m));
      check("R8 onehot", NM'($countones(mode_oh)), NM'(1));
      check("R9 route", NM'(obs), NM'(blk[m-1]));
    end
    pulse(3);
    check("R4 saturate", mode_oh, exp_oh(NM));
    leave_test();
  endtask

  task automatic t_reentry_and_ignore;
    pulse(3);
    check("R6 idle pulses mode", mode_oh, '0);
    norm = 1'b0; wait_neg(1);
    check("R10 norm follows", NM'(obs), NM'(norm));
    test_en = 1'b1; wait_neg(2);
    check("R6 entry after idle pulses", mode_oh, '0);
    pulse(1);
    check("R5 restart from zero", mode_oh, exp_oh(1));
    leave_test();
  endtask

  task automatic t_pin_high_entry;
    en_pin = 1'b1; wait_neg(5);
    test_en = 1'b1; wait_neg(5);
    check("R7 high level not counted", mode_oh, '0);
    en_pin = 1'b0; wait_neg(4);
    pulse(1);
    check("R7 next rise counted", mode_oh, exp_oh(1));
    blk = ~blk; wait_neg(1);
    check("R9 live route", NM'(obs), NM'(blk[0]));
    leave_test();
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    t_reset();
    t_single_and_double();
    t_every_mode();
    t_reentry_and_ignore();
    t_pin_high_entry();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule